// File: doc/BRIEF.md
# Tone Transceiver Host Register Interface

This block is the host-facing register file of a dual-tone telephone transceiver. A small processor reaches it over a 4-bit data bus, using an active-low chip select, active-low read and write strobes and one register-select line. Through this bus the host loads the tone code to transmit, reads the last decoded receive code and the status flags, and programs two control registers that share one address.

The block collects events from three neighbours. The receiver's delayed-steering level marks a validated tone pair. The burst timer pulses when a burst/pause cycle ends. The call-progress limiter gives a square wave. The block turns these into status flags and into one open-drain request line. That line carries one of three things, chosen by the control bits: a latched interrupt, a copy of the call-progress wave, or the inverted steering level for test.

The strobes are asynchronous to the block clock. They pass through a synchronizer, and each access takes effect once, on the rising edge of its synchronized strobe.

Top module: `tone_xcvr_regs`

## Requirements
- R1: While `cs_n` is low, the rising edge of `wr_n` with `rs`=0 loads `din` into `tx_code` and raises `tx_load` for exactly one cycle. With `rs`=1 it writes the control register instead. A strobe while `cs_n` is high changes nothing. The write lands on the third clock edge after `wr_n` rises (two synchronizer stages).
- R2: `dout_en` is high only while `cs_n` and `rd_n` are both low. During that time `dout` shows the receive code when `rs`=0 and the status word when `rs`=1; otherwise `dout` is 0. Status bits: bit3 = steering absent, bit2 = receive full, bit1 = transmit ready, bit0 = request seen.
- R3: Control register A bits: bit0 drives `tone_en`, bit1 drives `cp_mode` (1 = call-progress, 0 = dual-tone), bit2 enables the request line, and bit3 redirects the next control write to register B.
- R4: After a register-A write with bit3 set, only the next control write goes to register B, and it clears the redirect. Later control writes go to register A.
- R5: Control register B bits: bit0 drives `burst_off` (1 = burst timing disabled), bit1 drives `test_en`, bit2 drives `single_tone`, and bit3 drives `col_sel` (1 = column group, 0 = row group).
- R6: Reset clears both control registers, which selects dual-tone mode with burst timing on. It also sets the status word to 4'b1000, releases the request line and stops driving the bus.
- R7: A rising edge on `steer_dly` latches `rx_code` as the receive code and sets status bits 2 and 0 at that clock edge. Status bit3 follows the inverse of `steer_dly`, registered.
- R8: A `tx_done` pulse while burst timing is on sets status bits 1 and 0. While `burst_off` is 1, bit1 is held at 0 and `tx_done` is ignored.
- R9: A status read (`rd_n` rising with `rs`=1 and `cs_n` low) clears status bits 0, 1 and 2 after the data has been shown on the bus. A receive-code read clears nothing.
- R10: In dual-tone mode, with requests enabled and test mode off, `irq_oe` equals status bit0.
- R11: In call-progress mode with requests enabled, `irq_oe` is the inverse of `cp_sq`, whatever the test bit says. In call-progress mode with requests disabled, `irq_oe` is 0.
- R12: In dual-tone mode with test mode on, `irq_oe` equals `steer_dly`, whether or not requests are enabled. `irq_o` is always 0, so the pin is pulled low exactly while `irq_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rs | input | 1 | Register select |
| din | input | 4 | Bus data from host |
| dout | output | 4 | Bus data to host |
| dout_en | output | 1 | Bus driver enable |
| rx_code | input | 4 | Decoded code from the receiver |
| steer_dly | input | 1 | Delayed steering level from the receiver |
| tx_done | input | 1 | One-cycle pulse at the end of a burst/pause |
| cp_sq | input | 1 | Limited call-progress square wave |
| tx_code | output | 4 | Code to transmit |
| tx_load | output | 1 | One-cycle pulse when `tx_code` is written |
| tone_en | output | 1 | Tone output enable |
| cp_mode | output | 1 | Call-progress mode select |
| burst_off | output | 1 | Burst timing disabled |
| test_en | output | 1 | Test mode |
| single_tone | output | 1 | Single-tone generation |
| col_sel | output | 1 | Single-tone group: column (1) or row (0) |
| irq_oe | output | 1 | Open-drain enable for the request pin |
| irq_o | output | 1 | Request pin driver value, constant 0 |

## Verification
The bench goes after the one-shot redirect. A design that left the redirect set would send every later control write to register B. A design that cleared it too early would send the B write to register A.

It reads the receive code before the status, and then reads the status twice. A design that clears flags on any read, or clears them before the data is shown, would return a zero word on the first status read.

It lets a transmit-ready flag set and then turns burst timing off. It also pulses `tx_done` while burst timing is off. A design that forgot the burst gating would report a stale ready flag.

Finally it enables call-progress and test mode together with the steering input high. A design with the wrong pin priority would copy the steering level onto the pin instead of the square wave.

// File: rtl/tone_regs_pkg.sv
package tone_regs_pkg;
  localparam int DATA_W = 4;
  localparam int N_STROBE = 2;
  localparam int STB_WR = 0;
  localparam int STB_RD = 1;

  typedef struct packed {
    logic sel_b;
    logic irq_en;
    logic cp_mode;
    logic tone_en;
  } ctl_a_t;

  typedef struct packed {
    logic col_sel;
    logic single;
    logic test;
    logic burst_off;
  } ctl_b_t;

  typedef struct packed {
    logic steer_absent;
    logic rx_full;
    logic tx_ready;
    logic irq_seen;
  } status_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_n,
  output logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= '1;
    end else begin
      chain_q[0] <= raw_n;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import tone_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic [DATA_W-1:0] wdata,
  output ctl_a_t            ctl_a,
  output ctl_b_t            ctl_b
);
  ctl_a_t a_q, a_d;
  ctl_b_t b_q, b_d;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (wr_ctl) begin
      if (a_q.sel_b) begin
        b_d       = ctl_b_t'(wdata);
        a_d.sel_b = 1'b0;
      end else begin
        a_d = ctl_a_t'(wdata);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (wr_ctl) begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign ctl_a = a_q;
  assign ctl_b = b_q;
endmodule

// File: rtl/status_flags.sv
module status_flags
  import tone_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              steer,
  input  logic              tx_done,
  input  logic              burst_off,
  input  logic              clr,
  input  logic [DATA_W-1:0] rx_code,
  output status_t           st,
  output logic [DATA_W-1:0] rx_data
);
  status_t           st_q, st_d;
  logic [DATA_W-1:0] rx_q;
  logic              steer_q;
  logic              set_rx, set_tx;

  assign set_rx = steer & ~steer_q;
  assign set_tx = tx_done & ~burst_off;

  always_comb begin
    st_d.rx_full      = set_rx | (st_q.rx_full & ~clr);
    st_d.tx_ready     = ~burst_off & (set_tx | (st_q.tx_ready & ~clr));
    st_d.irq_seen     = set_rx | set_tx | (st_q.irq_seen & ~clr);
    st_d.steer_absent = ~steer;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= status_t'(4'b1000);
      steer_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      steer_q <= steer;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_q <= '0;
    else if (set_rx) rx_q <= rx_code;
  end

  assign st      = st_q;
  assign rx_data = rx_q;
endmodule

// File: rtl/irq_select.sv
module irq_select
  import tone_regs_pkg::*;
(
  input  ctl_a_t ctl_a,
  input  ctl_b_t ctl_b,
  input  logic   irq_seen,
  input  logic   steer,
  input  logic   cp_sq,
  output logic   pull
);
  always_comb begin
    pull = 1'b0;
    if (ctl_a.cp_mode) begin
      if (ctl_a.irq_en) pull = ~cp_sq;
    end else if (ctl_b.test) begin
      pull = steer;
    end else if (ctl_a.irq_en) begin
      pull = irq_seen;
    end
  end
endmodule

// File: rtl/tone_xcvr_regs.sv
module tone_xcvr_regs
  import tone_regs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              rs,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  input  logic [DATA_W-1:0] rx_code,
  input  logic              steer_dly,
  input  logic              tx_done,
  input  logic              cp_sq,
  output logic [DATA_W-1:0] tx_code,
  output logic              tx_load,
  output logic              tone_en,
  output logic              cp_mode,
  output logic              burst_off,
  output logic              test_en,
  output logic              single_tone,
  output logic              col_sel,
  output logic              irq_oe,
  output logic              irq_o
);
  localparam int CAP_W = DATA_W + 2;

  logic [N_STROBE-1:0] stb_lvl, stb_rise;
  logic [CAP_W-1:0]    cap_q;
  logic                cap_cs_n, cap_rs;
  logic [DATA_W-1:0]   cap_data;
  logic                acc_tx, acc_ctl, acc_stat;
  logic [DATA_W-1:0]   tx_q;
  logic                tx_load_q;
  ctl_a_t              ctl_a;
  ctl_b_t              ctl_b;
  status_t             st;
  logic [DATA_W-1:0]   rx_q;

  strobe_sync #(.STAGES(SYNC_STAGES), .W(N_STROBE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_n ({rd_n, wr_n}),
    .level (stb_lvl),
    .rise  (stb_rise)
  );

  // Address and data are held while either settled strobe is low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cap_q <= {1'b1, {(CAP_W-1){1'b0}}};
    else if (!(&stb_lvl))             cap_q <= {cs_n, rs, din};
  end

  assign {cap_cs_n, cap_rs, cap_data} = cap_q;

  assign acc_tx   = stb_rise[STB_WR] & ~cap_cs_n & ~cap_rs;
  assign acc_ctl  = stb_rise[STB_WR] & ~cap_cs_n &  cap_rs;
  assign acc_stat = stb_rise[STB_RD] & ~cap_cs_n &  cap_rs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tx_q <= '0;
    else if (acc_tx) tx_q <= cap_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_load_q <= 1'b0;
    else        tx_load_q <= acc_tx;
  end

  ctl_regs u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ctl (acc_ctl),
    .wdata  (cap_data),
    .ctl_a  (ctl_a),
    .ctl_b  (ctl_b)
  );

  status_flags u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .steer     (steer_dly),
    .tx_done   (tx_done),
    .burst_off (ctl_b.burst_off),
    .clr       (acc_stat),
    .rx_code   (rx_code),
    .st        (st),
    .rx_data   (rx_q)
  );

  irq_select u_irq (
    .ctl_a    (ctl_a),
    .ctl_b    (ctl_b),
    .irq_seen (st.irq_seen),
    .steer    (steer_dly),
    .cp_sq    (cp_sq),
    .pull     (irq_oe)
  );

  assign dout_en     = ~cs_n & ~rd_n;
  assign dout        = dout_en ? (rs ? DATA_W'(st) : rx_q) : '0;
  assign tx_code     = tx_q;
  assign tx_load     = tx_load_q;
  assign tone_en     = ctl_a.tone_en;
  assign cp_mode     = ctl_a.cp_mode;
  assign burst_off   = ctl_b.burst_off;
  assign test_en     = ctl_b.test;
  assign single_tone = ctl_b.single;
  assign col_sel     = ctl_b.col_sel;
  assign irq_o       = 1'b0;
endmodule

// File: rtl/tone_xcvr_regs_chk.sv
module tone_xcvr_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rd_n,
  input logic       dout_en,
  input logic       acc_ctl,
  input logic       sel_b,
  input logic       irq_en,
  input logic       cp_mode,
  input logic       test_en,
  input logic       burst_off,
  input logic       steer_dly,
  input logic       cp_sq,
  input logic [3:0] rx_code,
  input logic [3:0] rx_q,
  input logic [3:0] st,
  input logic       tx_load,
  input logic       irq_oe
);
  AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> !dout_en);                                        // R2
  AST_REDIRECT_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ctl && sel_b) |=> !sel_b);                                      // R4
  AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steer_dly) |=> (rx_q == $past(rx_code) && st[2] && st[0]));    // R7
  AST_READY_NEEDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    burst_off |=> !st[1]);                                               // R8
  AST_TX_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load);                                               // R1
  AST_CP_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_mode && irq_en) |-> (irq_oe == !cp_sq));                         // R11
  AST_IRQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !cp_mode && !test_en) |-> (irq_oe == st[0]));             // R10
endmodule

bind tone_xcvr_regs tone_xcvr_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .rd_n      (rd_n),
  .dout_en   (dout_en),
  .acc_ctl   (acc_ctl),
  .sel_b     (ctl_a.sel_b),
  .irq_en    (ctl_a.irq_en),
  .cp_mode   (ctl_a.cp_mode),
  .test_en   (ctl_b.test),
  .burst_off (ctl_b.burst_off),
  .steer_dly (steer_dly),
  .cp_sq     (cp_sq),
  .rx_code   (rx_code),
  .rx_q      (rx_q),
  .st        (st),
  .tx_load   (tx_load),
  .irq_oe    (irq_oe)
);

// File: tb/tone_xcvr_regs_tb.sv
module tone_xcvr_regs_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rs = 1'b0;
  logic [3:0] din = '0, rx_code = '0;
  logic steer_dly = 1'b0, tx_done = 1'b0, cp_sq = 1'b1;
  logic [3:0] dout, tx_code;
  logic dout_en, tx_load, tone_en, cp_mode, burst_off, test_en, single_tone, col_sel;
  logic irq_oe, irq_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tone_xcvr_regs u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .rs(rs),
    .din(din), .dout(dout), .dout_en(dout_en), .rx_code(rx_code),
    .steer_dly(steer_dly), .tx_done(tx_done), .cp_sq(cp_sq),
    .tx_code(tx_code), .tx_load(tx_load), .tone_en(tone_en), .cp_mode(cp_mode),
    .burst_off(burst_off), .test_en(test_en), .single_tone(single_tone),
    .col_sel(col_sel), .irq_oe(irq_oe), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: strobe histories sampled each edge, flags as integers.
  logic [4:1] hw, hr;
  logic [2:1] hc, hs;
  logic [3:0] hd1, hd2;
  logic [3:0] m_cra, m_crb, m_st, m_rx, m_tx;
  logic m_txl, m_sp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw = '1; hr = '1; hc = '1; hs = '0; hd1 = '0; hd2 = '0;
      m_cra = 0; m_crb = 0; m_st = 4'b1000; m_rx = 0; m_tx = 0; m_txl = 0; m_sp = 0;
    end else begin
      bit wr_rise, rd_rise, set_rx, set_tx, clr, bon;
      hw = {hw[3:1], wr_n};
      hr = {hr[3:1], rd_n};
      hc = {hc[1], cs_n};
      hs = {hs[1], rs};
      hd2 = hd1; hd1 = din;
      wr_rise = hw[3] && !hw[4];
      rd_rise = hr[3] && !hr[4];
      bon = !m_crb[0];
      set_rx = steer_dly && !m_sp;
      set_tx = tx_done && bon;
      clr = rd_rise && !hc[2] && hs[2];
      m_st[2] = set_rx || (m_st[2] && !clr);
      m_st[1] = bon && (set_tx || (m_st[1] && !clr));
      m_st[0] = set_rx || set_tx || (m_st[0] && !clr);
      m_st[3] = !steer_dly;
      if (set_rx) m_rx = rx_code;
      m_sp = steer_dly;
      m_txl = wr_rise && !hc[2] && !hs[2];
      if (m_txl) m_tx = hd2;
      if (wr_rise && !hc[2] && hs[2]) begin
        if (m_cra[3]) begin m_crb = hd2; m_cra[3] = 1'b0; end
        else m_cra = hd2;
      end
    end
  end

  function automatic logic model_irq();
    if (m_cra[1]) return m_cra[2] ? !cp_sq : 1'b0;
    if (m_crb[1]) return steer_dly;
    if (m_cra[2]) return m_st[0];
    return 1'b0;
  endfunction

  // Compare every clock, one time unit before the rising edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1.5;
      chk("R1 tx_code", tx_code, m_tx);
      chk("R1 tx_load", tx_load, m_txl);
      chk("R3 ctlA", {tone_en, cp_mode}, {m_cra[0], m_cra[1]});
      chk("R5 ctlB", {burst_off, test_en, single_tone, col_sel}, {m_crb[0], m_crb[1], m_crb[2], m_crb[3]});
      chk("R2 dout_en", dout_en, !cs_n && !rd_n);
      chk("R2 dout", dout, (!cs_n && !rd_n) ? (rs ? m_st : m_rx) : 4'h0);
      chk("R10 irq_oe", irq_oe, model_irq());
      chk("R12 irq_o", irq_o, 1'b0);
    end
  end

  task automatic bus_write(input logic sel, input logic [3:0] d, input logic chip_n = 1'b0);
    @(negedge clk); cs_n = chip_n; rs = sel; din = d; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(input logic sel, output logic [3:0] v);
    @(negedge clk); cs_n = 1'b0; rs = sel; rd_n = 1'b0;
    repeat (2) @(negedge clk);
    #1; v = dout;
    @(negedge clk); rd_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [3:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R6 bus idle", dout_en, 1'b0);
    chk("R6 irq released", irq_oe, 1'b0);
    chk("R6 controls", {tone_en, cp_mode, burst_off, test_en, single_tone, col_sel}, 6'b0);
    bus_read(1'b1, v); chk("R6 status", v, 4'h8);

    bus_write(1'b0, 4'h5); chk("R1 tx write", tx_code, 4'h5);
    bus_write(1'b0, 4'hA, 1'b1); chk("R1 cs high ignored", tx_code, 4'h5);
    bus_write(1'b1, 4'hB, 1'b1); chk("R1 cs high ctl ignored", tone_en, 1'b0);

    bus_write(1'b1, 4'b0101); chk("R3 tone_en", tone_en, 1'b1);
    bus_write(1'b1, 4'b1000);
    bus_write(1'b1, 4'b0110);
    chk("R4 redirect to B", {test_en, single_tone, col_sel}, 3'b110);
    chk("R5 burst on", burst_off, 1'b0);
    bus_write(1'b1, 4'b0001);
    chk("R4 back to A", tone_en, 1'b1);
    chk("R4 B unchanged", {test_en, single_tone}, 2'b11);

    @(negedge clk); rx_code = 4'h9; steer_dly = 1'b1;
    @(negedge clk); #1; chk("R12 test pin follows steering", irq_oe, 1'b1);
    bus_read(1'b0, v); chk("R7 rx code", v, 4'h9);
    bus_read(1'b1, v); chk("R9 rx read keeps flags", v, 4'h5);
    bus_read(1'b1, v); chk("R9 status cleared", v, 4'h0);
    @(negedge clk); steer_dly = 1'b0;
    @(negedge clk); #1; chk("R12 test pin released", irq_oe, 1'b0);
    bus_read(1'b1, v); chk("R7 absence flag", v, 4'h8);

    bus_write(1'b1, 4'b1100);
    bus_write(1'b1, 4'b1000);
    chk("R5 col_sel", col_sel, 1'b1);
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0; #1;
    chk("R10 request on ready", irq_oe, 1'b1);
    bus_read(1'b1, v); chk("R8 ready flag", v, 4'hB);
    chk("R9 request cleared", irq_oe, 1'b0);

    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    bus_write(1'b1, 4'b1100);
    bus_write(1'b1, 4'b0001);
    bus_read(1'b1, v); chk("R8 burst off drops ready", v, 4'h9);
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    bus_read(1'b1, v); chk("R8 done ignored when burst off", v, 4'h8);

    bus_write(1'b1, 4'b1110);
    bus_write(1'b1, 4'b0011);
    @(negedge clk); steer_dly = 1'b1; cp_sq = 1'b1;
    @(negedge clk); #1; chk("R11 cp high released", irq_oe, 1'b0);
    @(negedge clk); cp_sq = 1'b0;
    #1; chk("R11 cp low pulls", irq_oe, 1'b1);
    bus_write(1'b1, 4'b0010);
    chk("R11 cp without enable", irq_oe, 1'b0);
    @(negedge clk); steer_dly = 1'b0; cp_sq = 1'b1;
    repeat (4) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule